// File: doc/BRIEF.md
# Dual-Clock FIFO with Early Drain Warning

This block buffers data words between two unrelated clock domains. A producer on the write clock pushes words with a write enable and holds off while `full` is high. A consumer on the read clock sees the oldest stored word at `rdata` whenever `empty` is low, and takes it with a read enable. Each side keeps a binary pointer with one wrap bit beyond the address. Only the Gray form of a pointer crosses to the other domain, through a flip-flop synchronizer clocked and reset by the destination side.

Besides `empty`, the read side raises `almost_empty` while few words remain. To do this it turns the synchronized Gray write pointer back into binary and subtracts the next read pointer. The subtraction is taken modulo twice the depth, so it stays correct when the pointers wrap. With the default margin of two, a consumer that drains steadily sees `almost_empty` two read cycles before `empty`. It can use that warning to stop issuing requests in good time.

Top module: `dcfifo_ae`

## Requirements
- R1: While reset is applied, `empty` = 1, `almost_empty` = 1 and `full` = 0. Each domain has its own active-low asynchronous reset.
- R2: Words leave in the order they were accepted. While `empty` is 0, `rdata` shows the oldest unread word.
- R3: A write is accepted on a write-clock edge only when `wen` = 1 and `full` = 0. A write attempted while full is dropped, so a full FIFO holds exactly 2^ADDR_W words.
- R4: A read is accepted on a read-clock edge only when `ren` = 1 and `empty` = 0. A read attempted while empty does not move the read pointer.
- R5: `full` is a register on the write clock. After an edge, it is 1 exactly when the updated write pointer is 2^ADDR_W ahead of the synchronized read pointer.
- R6: `empty` is a register on the read clock. After an edge, it is 1 exactly when the updated read pointer equals the synchronized write pointer.
- R7: `almost_empty` is a register on the read clock. After an edge, it is 1 exactly when (synchronized write pointer − updated read pointer) mod 2^(ADDR_W+1) is at most AE_MARGIN (default 2). With steady reads and no new writes, it rises two read cycles before `empty`, and it falls once that level reaches AE_MARGIN+1.
- R8: Pointers cross domains as Gray code (bin XOR bin>>1), changing at most one bit per edge, through a synchronizer of SYNC_STAGES (default 2) flops. A single write into an idle empty FIFO clears `empty` at the third read-clock edge after the write edge.
- R9: Fill level, flags and data order stay correct over many passes of both pointers around the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| wen | input | 1 | Write request |
| wdata | input | DATA_W | Word to store |
| full | output | 1 | Registered full flag, write domain |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| ren | input | 1 | Read request |
| rdata | output | DATA_W | Oldest stored word |
| empty | output | 1 | Registered empty flag, read domain |
| almost_empty | output | 1 | Registered early drain warning, read domain |

## Verification
A write landing in the same stretch of time as a read can move the fill level across the almost-empty margin in both directions at once. The read side then sees a stale synchronized write pointer while its own pointer advances. The bench provokes this with rate-biased random traffic on both sides, using read and write periods that share no common edge, and with long phases that hover near empty and near full. Each flag and each delivered word is judged on every cycle against a queue model that imitates the two-edge pointer delay independently.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
   // smallest synchronizer depth accepted for a pointer crossing
   localparam int unsigned MIN_SYNC_STAGES = 2;
   // smallest address width for which the two-MSB full test is meaningful
   localparam int unsigned MIN_ADDR_W = 2;
endpackage : dcf_pkg

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule : dcf_sync

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 4
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   // show-ahead: the word at the read address is always visible
   assign rdata = cells[raddr];
endmodule : dcf_mem

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
module dcf_wr_ctrl #(
   parameter int unsigned AW = 4
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wen_i,
   input  logic [AW:0]   rgray_s_i,
   output logic          full_o,
   output logic          push_o,
   output logic [AW-1:0] waddr_o,
   output logic [AW:0]   wgray_o
);
   logic [AW:0] wbin_q, wbin_nx, wgray_nx, full_pat;

   assign push_o   = wen_i & ~full_o;
   assign wbin_nx  = wbin_q + {{AW{1'b0}}, push_o};
   assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
   // a lap ahead in Gray form: top two bits flipped, the rest equal
   assign full_pat = {~rgray_s_i[AW:AW-1], rgray_s_i[AW-2:0]};

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin_q  <= '0;
         wgray_o <= '0;
         full_o  <= 1'b0;
      end else begin
         wbin_q  <= wbin_nx;
         wgray_o <= wgray_nx;
         full_o  <= (wgray_nx == full_pat);
      end
   end

   assign waddr_o = wbin_q[AW-1:0];

   // R3: blocked writes leave the pointer alone
   a_r3_hold_when_blocked: assert property (@(posedge wclk) disable iff (!wrst_n)
      (!wen_i || full_o) |=> $stable(wbin_q));
   // R3: an accepted write moves the pointer by one
   a_r3_step_on_push: assert property (@(posedge wclk) disable iff (!wrst_n)
      (wen_i && !full_o) |=> (wbin_q == $past(wbin_q) + 1'b1));
   // R5: full can only appear right after an accepted write
   a_r5_full_after_push: assert property (@(posedge wclk) disable iff (!wrst_n)
      $rose(full_o) |-> $past(wen_i && !full_o));
   // R8: the crossing pointer changes at most one bit per edge
   a_r8_wgray_one_bit: assert property (@(posedge wclk) disable iff (!wrst_n)
      1'b1 |=> ($countones(wgray_o ^ $past(wgray_o)) <= 1));
endmodule : dcf_wr_ctrl

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
module dcf_rd_ctrl #(
   parameter int unsigned AW     = 4,
   parameter int unsigned MARGIN = 2
) (
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          ren_i,
   input  logic [AW:0]   wgray_s_i,
   output logic          empty_o,
   output logic          aempty_o,
   output logic [AW-1:0] raddr_o,
   output logic [AW:0]   rgray_o
);
   localparam logic [AW:0] MARGIN_V = MARGIN[AW:0];

   logic        pop;
   logic [AW:0] rbin_q, rbin_nx, rgray_nx, wbin_s, level;

   assign pop      = ren_i & ~empty_o;
   assign rbin_nx  = rbin_q + {{AW{1'b0}}, pop};
   assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;

   // Gray to binary: top bit copied, each lower bit folds in the one above
   always_comb begin
      wbin_s[AW] = wgray_s_i[AW];
      for (int i = AW - 1; i >= 0; i--) begin
         wbin_s[i] = wbin_s[i+1] ^ wgray_s_i[i];
      end
   end

   // modulo 2^(AW+1) difference is the level even across wrap
   assign level = wbin_s - rbin_nx;

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin_q   <= '0;
         rgray_o  <= '0;
         empty_o  <= 1'b1;
         aempty_o <= 1'b1;
      end else begin
         rbin_q   <= rbin_nx;
         rgray_o  <= rgray_nx;
         empty_o  <= (rgray_nx == wgray_s_i);
         aempty_o <= (level <= MARGIN_V);
      end
   end

   assign raddr_o = rbin_q[AW-1:0];

   // R4: blocked reads leave the pointer alone
   a_r4_hold_when_blocked: assert property (@(posedge rclk) disable iff (!rrst_n)
      (!ren_i || empty_o) |=> $stable(rbin_q));
   // R4: an accepted read moves the pointer by one
   a_r4_step_on_pop: assert property (@(posedge rclk) disable iff (!rrst_n)
      (ren_i && !empty_o) |=> (rbin_q == $past(rbin_q) + 1'b1));
   // R7: an empty FIFO is always almost empty
   a_r7_empty_implies_ae: assert property (@(posedge rclk) disable iff (!rrst_n)
      empty_o |-> aempty_o);
   // R7: the warning is already up one cycle before empty appears
   a_r7_ae_leads_empty: assert property (@(posedge rclk) disable iff (!rrst_n)
      $rose(empty_o) |-> $past(aempty_o));
   // R8: the crossing pointer changes at most one bit per edge
   a_r8_rgray_one_bit: assert property (@(posedge rclk) disable iff (!rrst_n)
      1'b1 |=> ($countones(rgray_o ^ $past(rgray_o)) <= 1));
endmodule : dcf_rd_ctrl

// File: rtl/dcfifo_ae.sv
`timescale 1ns/1ps
module dcfifo_ae #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned AE_MARGIN   = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              wen,
   input  logic [DATA_W-1:0] wdata,
   output logic              full,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              ren,
   output logic [DATA_W-1:0] rdata,
   output logic              empty,
   output logic              almost_empty
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned PTR_W = ADDR_W + 1;

   if (ADDR_W < dcf_pkg::MIN_ADDR_W) begin : g_bad_addr
      $error("dcfifo_ae: ADDR_W must be at least %0d", dcf_pkg::MIN_ADDR_W);
   end
   if (SYNC_STAGES < dcf_pkg::MIN_SYNC_STAGES) begin : g_bad_sync
      $error("dcfifo_ae: SYNC_STAGES must be at least %0d", dcf_pkg::MIN_SYNC_STAGES);
   end
   if (AE_MARGIN < 1 || AE_MARGIN >= DEPTH) begin : g_bad_margin
      $error("dcfifo_ae: AE_MARGIN must lie in 1..DEPTH-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dcfifo_ae: DATA_W must be positive");
   end

   logic              push;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;

   dcf_wr_ctrl #(.AW(ADDR_W)) u_wr (
      .wclk      (wclk),
      .wrst_n    (wrst_n),
      .wen_i     (wen),
      .rgray_s_i (rgray_s),
      .full_o    (full),
      .push_o    (push),
      .waddr_o   (waddr),
      .wgray_o   (wgray)
   );

   dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk   (wclk),
      .rst_n (wrst_n),
      .d     (rgray),
      .q     (rgray_s)
   );

   dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk   (rclk),
      .rst_n (rrst_n),
      .d     (wgray),
      .q     (wgray_s)
   );

   dcf_rd_ctrl #(.AW(ADDR_W), .MARGIN(AE_MARGIN)) u_rd (
      .rclk      (rclk),
      .rrst_n    (rrst_n),
      .ren_i     (ren),
      .wgray_s_i (wgray_s),
      .empty_o   (empty),
      .aempty_o  (almost_empty),
      .raddr_o   (raddr),
      .rgray_o   (rgray)
   );

   dcf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
      .wclk  (wclk),
      .we    (push),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (rdata)
   );
endmodule : dcfifo_ae

// File: tb/tb_dcfifo_ae.sv
`timescale 1ns/1ps
module tb_dcfifo_ae;
   localparam int DW     = 8;
   localparam int AW     = 4;
   localparam int DEPTH  = 1 << AW;
   localparam int MARGIN = 2;

   logic          wclk = 1'b0, rclk = 1'b0;
   logic          wrst_n, rrst_n;
   logic          wen = 1'b0, ren = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic          full, empty, almost_empty;
   logic [DW-1:0] rdata;

   int tests = 0, fails = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;
   int wmode = 0, rmode = 0;
   logic [DW-1:0] wseq = 8'h30;

   // behavioural model state
   int wcnt, rcnt, ws1, ws2, rs1, rs2, wnext, rnext;
   bit full_m, empty_m, ae_m;
   logic [DW-1:0] q[$];

   dcfifo_ae dut (
      .wclk(wclk), .wrst_n(wrst_n), .wen(wen), .wdata(wdata), .full(full),
      .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .rdata(rdata),
      .empty(empty), .almost_empty(almost_empty)
   );

   // 200 MHz write clock; read clock 7 ns, offset so edges never meet
   always #2.5 wclk = ~wclk;
   initial begin
      #0.3;
      forever #3.5 rclk = ~rclk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // write-side model: accepted write, full, two-edge read pointer delay
   always @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wcnt = 0; rs1 = 0; rs2 = 0; full_m = 1'b0;
      end else begin
         wnext = wcnt;
         if (wen && !full_m) begin
            q.push_back(wdata);
            wnext = wcnt + 1;
         end
         full_m = ((wnext - rs2) == DEPTH);
         rs2 = rs1;
         rs1 = rcnt;
         wcnt = wnext;
      end
   end

   // read-side model: accepted read, empty, almost-empty
   always @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rcnt = 0; ws1 = 0; ws2 = 0; empty_m = 1'b1; ae_m = 1'b1;
      end else begin
         rnext = rcnt;
         if (ren && !empty_m) begin
            void'(q.pop_front());
            rnext = rcnt + 1;
         end
         empty_m = (ws2 == rnext);
         ae_m    = ((ws2 - rnext) <= MARGIN);
         ws2 = ws1;
         ws1 = wcnt;
         rcnt = rnext;
      end
   end

   // stimulus drivers, away from the active edges
   always @(negedge wclk) begin
      case (wmode)
         1:       wen <= 1'b1;
         2:       wen <= ($urandom_range(99, 0) < 50);
         3:       wen <= ($urandom_range(99, 0) < 25);
         default: wen <= 1'b0;
      endcase
      wdata <= wseq;
      wseq  <= wseq + 8'd7;
   end

   always @(negedge rclk) begin
      case (rmode)
         1:       ren <= 1'b1;
         2:       ren <= ($urandom_range(99, 0) < 50);
         3:       ren <= ($urandom_range(99, 0) < 80);
         default: ren <= 1'b0;
      endcase
   end

   // per-cycle comparison against the model
   always @(negedge rclk) begin
      if (chk_on && !done) begin
         chk(empty === empty_m, "R6", "empty", int'(empty), int'(empty_m));
         chk(almost_empty === ae_m, "R7", "almost_empty", int'(almost_empty), int'(ae_m));
         if (!empty_m && q.size() > 0)
            chk(rdata === q[0], "R2", "rdata", int'(rdata), int'(q[0]));
      end
   end

   always @(negedge wclk) begin
      if (chk_on && !done)
         chk(full === full_m, "R5", "full", int'(full), int'(full_m));
   end

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int ae_idx, e_idx, n_drained, n_edges;
      logic [DW-1:0] lastw;
      wrst_n = 1'b0;
      rrst_n = 1'b0;
      repeat (4) @(negedge wclk);
      // R1: reset state
      chk(empty === 1'b1, "R1", "empty in reset", int'(empty), 1);
      chk(almost_empty === 1'b1, "R1", "almost_empty in reset", int'(almost_empty), 1);
      chk(full === 1'b0, "R1", "full in reset", int'(full), 0);
      @(negedge wclk) wrst_n = 1'b1;
      @(negedge rclk) rrst_n = 1'b1;
      chk_on = 1'b1;
      repeat (4) @(negedge wclk);

      // R3/R5: fill to full and keep pushing
      wmode = 1;
      repeat (60) @(negedge wclk);
      wmode = 0;
      repeat (6) @(negedge wclk);
      chk(full === 1'b1, "R5", "full after overfill", int'(full), 1);

      // R7/R3/R4: steady drain, then keep reading while empty
      ae_idx = -1; e_idx = -1; n_drained = 0;
      rmode = 1;
      for (int k = 0; k < 40; k++) begin
         @(negedge rclk);
         #0.5;
         if (!empty) n_drained++;
         if (almost_empty && ae_idx < 0) ae_idx = k;
         if (empty && e_idx < 0) e_idx = k;
      end
      chk(n_drained == DEPTH, "R3", "words kept after overfill", n_drained, DEPTH);
      chk((e_idx - ae_idx) == 2, "R7", "almost_empty lead over empty", e_idx - ae_idx, 2);
      rmode = 0;
      repeat (4) @(negedge rclk);

      // R8/R4: single write into idle empty FIFO
      wmode = 1;
      @(negedge wclk);
      @(posedge wclk);
      wmode = 0;
      lastw = wdata;
      n_edges = 0;
      for (int k = 0; k < 10; k++) begin
         @(posedge rclk);
         n_edges++;
         #1;
         if (!empty) break;
      end
      chk(n_edges == 3, "R8", "read edges until empty clears", n_edges, 3);
      chk(rdata === lastw, "R4", "word after reads while empty", int'(rdata), int'(lastw));
      rmode = 1;
      repeat (6) @(negedge rclk);

      // R9: balanced random traffic, many wraps
      wmode = 2; rmode = 2;
      repeat (3000) @(negedge wclk);
      // near full: writer dominates
      wmode = 1; rmode = 2;
      repeat (600) @(negedge wclk);
      // near empty: reader dominates, crossings at the margin
      wmode = 3; rmode = 3;
      repeat (1500) @(negedge wclk);
      wmode = 2; rmode = 1;
      repeat (800) @(negedge wclk);
      wmode = 0;
      repeat (80) @(negedge rclk);
      chk(empty === 1'b1, "R9", "empty after final drain", int'(empty), 1);
      chk(q.size() == 0, "R9", "model queue after drain", q.size(), 0);
      rmode = 0;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule : tb_dcfifo_ae